// File: doc/BRIEF.md
# Configurable USART Frame Transmitter

This block turns one character into a serial frame on a single transmit line. A frame opens with one low start bit. The data bits follow, and there may be 5 to 9 of them. A parity bit is optional, and one or two high stop bits close the frame. The line rests high between frames. Characters arrive on a valid/ready handshake. The frame options come from static configuration pins: size code, parity kind, stop count, bit order, clock mode and clock polarity. The block samples all of them at the moment it accepts a character.

The block has two pacing modes. In asynchronous mode each bit lasts until the next pulse of an external baud tick enable. In synchronous master mode the block makes its own bit clock at half the module clock and drives it on `xck_o`. That clock toggles only while a frame is in flight and otherwise holds a selectable rest level. A character presented during the last cycle of the final stop bit starts the next frame at once, so frames can run back to back with no idle gap.

Top module: `usart_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in flight, `tx_o` is 1, `ready_o` is 1 and `busy_o` is 0.
- R2: A character accepted on a clock edge (valid_i and ready_o both high) makes `busy_o` 1 and `tx_o` 0 (the start bit) from the next cycle.
- R3: The size code `size_code_i` selects the number of data bits. Codes 5, 6 and 7 give 5, 6 and 7 bits. Code 1 gives 9 bits. Code 0 gives 8 bits, and the unused codes 2, 3 and 4 also give 8 bits. Data bits above the selected width are ignored.
- R4: With `lsb_first_i`=1 the data bits go out from bit 0 upward. With `lsb_first_i`=0 they go out from the top bit of the selected width downward.
- R5: `parity_i` selects the parity: 2'b10 is even, 2'b11 is odd, and 2'b00 or 2'b01 is none. Even parity makes the count of ones over the data and parity bits even, and odd parity makes it odd. With none, the stop field follows the last data bit directly.
- R6: `two_stop_i`=0 gives one stop bit and 1 gives two. Stop bits are 1.
- R7: In asynchronous mode (`sync_mode_i`=0) a bit ends on the clock edge that samples `baud_tick_i` high, and `tx_o` holds its value over every cycle in which the tick is low.
- R8: In synchronous mode (`sync_mode_i`=1) every bit lasts two clock cycles. `xck_o` toggles every cycle while a frame is in flight. `tx_o` changes only on the edge where `xck_o` returns to its rest level, so it is stable at the opposite edge.
- R9: The rest level of `xck_o` equals `xck_inv_i`. With 0, data changes on falling XCK edges and is sampled on rising ones, and 1 swaps the two edges. When idle, `xck_o` follows `xck_inv_i`.
- R10: `ready_o` is high only when idle, or in the last cycle of the final stop bit. A character accepted in that cycle starts its start bit on the next cycle, with no idle cycle between the frames.
- R11: Changes to the data or configuration inputs after acceptance do not affect the frame in flight.
- R12: `valid_i` while `ready_o` is low is ignored: no character is taken and no extra frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_mode_i | input | 1 | 1: synchronous master, 0: asynchronous |
| baud_tick_i | input | 1 | One-cycle bit-period enable (asynchronous mode) |
| size_code_i | input | 3 | Character size code |
| parity_i | input | 2 | Parity select |
| two_stop_i | input | 1 | Two stop bits when 1 |
| lsb_first_i | input | 1 | Bit order select |
| xck_inv_i | input | 1 | XCK rest level / edge polarity |
| data_i | input | 9 | Character, right aligned |
| valid_i | input | 1 | Character available |
| ready_o | output | 1 | Character can be taken this cycle |
| tx_o | output | 1 | Serial data line |
| xck_o | output | 1 | Synchronous bit clock |
| busy_o | output | 1 | Frame in flight |

## Verification
A bad bit counter or a wrong state transition shows up as a frame with the wrong length. The bench catches it within one frame, because it rebuilds every bit at the receiver's sampling point and compares the whole sequence. A wrongly latched configuration or a bad shift source shows up as a corrupted or reordered data field in the same frame. A phase register that goes wrong in synchronous mode shows up as a missing XCK toggle, or a data change while XCK is away from rest, in the very next cycle. A handshake error shows up either as an idle gap between back-to-back frames or as a spurious frame after a frame that received valid_i mid-flight.

// File: rtl/uftx_pkg.sv
package uftx_pkg;
  localparam int unsigned MAX_DW = 9;
  localparam int unsigned CNT_W  = $clog2(MAX_DW + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP
  } tx_state_e;

  // fields that must survive past the accept edge
  typedef struct packed {
    logic             sync;
    logic             inv;
    logic             two_stop;
    logic             par_en;
    logic [CNT_W-1:0] nbits;
  } frame_cfg_t;
endpackage

// File: rtl/uftx_cfg_decode.sv
module uftx_cfg_decode
  import uftx_pkg::*;
(
  input  logic       sync_mode_i,
  input  logic       xck_inv_i,
  input  logic       two_stop_i,
  input  logic [2:0] size_code_i,
  input  logic [1:0] parity_i,
  output frame_cfg_t cfg_o,
  output logic       par_odd_o
);
  logic [CNT_W-1:0] nbits;

  always_comb begin
    unique case (size_code_i)
      3'd5:    nbits = CNT_W'(5);
      3'd6:    nbits = CNT_W'(6);
      3'd7:    nbits = CNT_W'(7);
      3'd1:    nbits = CNT_W'(9);
      default: nbits = CNT_W'(8);
    endcase
  end

  always_comb begin
    cfg_o.sync     = sync_mode_i;
    cfg_o.inv      = xck_inv_i;
    cfg_o.two_stop = two_stop_i;
    cfg_o.par_en   = parity_i[1];
    cfg_o.nbits    = nbits;
  end

  assign par_odd_o = parity_i[1] & parity_i[0];
endmodule

// File: rtl/uftx_char_prep.sv
module uftx_char_prep
  import uftx_pkg::*;
#(
  parameter int unsigned DATA_W = MAX_DW
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  nbits_i,
  input  logic              lsb_first_i,
  output logic [DATA_W-1:0] ord_o,
  output logic              xor_o
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  // ord_o is consumed bit 0 first by a right shifter
  always_comb begin
    ord_o = '0;
    xor_o = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (CNT_W'(i) < nbits_i) begin
        xor_o ^= data_i[i];
        if (lsb_first_i) ord_o[i] = data_i[i];
        else             ord_o[i] = data_i[IDX_W'(int'(nbits_i) - 1 - i)];
      end
    end
  end
endmodule

// File: rtl/uftx_pacer.sv
module uftx_pacer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic sync_i,
  input  logic inv_i,
  input  logic baud_tick_i,
  output logic step_o,
  output logic xck_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                phase_q <= 1'b0;
    else if (!run_i || !sync_i) phase_q <= 1'b0;
    else                        phase_q <= ~phase_q;
  end

  assign step_o = sync_i ? phase_q : baud_tick_i;
  assign xck_o  = inv_i ^ phase_q;

  a_r8_xck_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && sync_i && $past(run_i) && $past(sync_i)) |-> (xck_o != $past(xck_o)));

  a_r8_two_cycle_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && sync_i && step_o) |=> !step_o);
endmodule

// File: rtl/uftx_seq.sv
module uftx_seq
  import uftx_pkg::*;
#(
  parameter int unsigned DATA_W = MAX_DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              step_i,
  input  frame_cfg_t        cfg_i,
  input  logic              par_odd_i,
  input  logic [DATA_W-1:0] char_i,
  input  logic              xor_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              tx_o,
  output logic              sync_q_o,
  output logic              inv_q_o
);
  tx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic              par_q;
  frame_cfg_t        cfg_q;
  logic              last_stop, accept;
  logic [CNT_W-1:0]  stop_cnt;

  assign stop_cnt  = {{(CNT_W-1){1'b0}}, cfg_q.two_stop};
  assign last_stop = (state_q == S_STOP) && (cnt_q == '0);
  assign ready_o   = (state_q == S_IDLE) || (last_stop && step_i);
  assign accept    = valid_i && ready_o;
  assign busy_o    = (state_q != S_IDLE);
  assign sync_q_o  = cfg_q.sync;
  assign inv_q_o   = cfg_q.inv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) state_q <= S_START;
        S_START: if (step_i) begin
          state_q <= S_DATA;
          cnt_q   <= cfg_q.nbits - CNT_W'(1);
        end
        S_DATA: if (step_i) begin
          if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
          else if (cfg_q.par_en) state_q <= S_PAR;
          else begin
            state_q <= S_STOP;
            cnt_q   <= stop_cnt;
          end
        end
        S_PAR: if (step_i) begin
          state_q <= S_STOP;
          cnt_q   <= stop_cnt;
        end
        S_STOP: if (step_i) begin
          if (cnt_q != '0) cnt_q   <= cnt_q - CNT_W'(1);
          else if (accept) state_q <= S_START;
          else             state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      par_q   <= 1'b0;
      cfg_q   <= '0;
    end else if (accept) begin
      shreg_q <= char_i;
      par_q   <= xor_i ^ par_odd_i;
      cfg_q   <= cfg_i;
    end else if (state_q == S_DATA && step_i) begin
      shreg_q <= shreg_q >> 1;
    end
  end

  always_comb begin
    unique case (state_q)
      S_START: tx_o = 1'b0;
      S_DATA:  tx_o = shreg_q[0];
      S_PAR:   tx_o = par_q;
      default: tx_o = 1'b1;
    endcase
  end

  a_r2_start_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (busy_o && !tx_o && state_q == S_START));

  a_r10_ready_scope: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (state_q == S_IDLE || state_q == S_STOP));

  a_r12_no_midframe_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE && state_q != S_START && !ready_o) |=> (state_q != S_START));

  a_r5_no_parity_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DATA && !cfg_q.par_en) |=> (state_q != S_PAR));
endmodule

// File: rtl/usart_frame_tx.sv
module usart_frame_tx
  import uftx_pkg::*;
#(
  parameter int unsigned DATA_W = MAX_DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_mode_i,
  input  logic              baud_tick_i,
  input  logic [2:0]        size_code_i,
  input  logic [1:0]        parity_i,
  input  logic              two_stop_i,
  input  logic              lsb_first_i,
  input  logic              xck_inv_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              tx_o,
  output logic              xck_o,
  output logic              busy_o
);
  frame_cfg_t        cfg_live;
  logic              par_odd, pxor, step, sync_q, inv_q, sync_act, inv_act;
  logic [DATA_W-1:0] ord;

  uftx_cfg_decode u_dec (
    .sync_mode_i (sync_mode_i),
    .xck_inv_i   (xck_inv_i),
    .two_stop_i  (two_stop_i),
    .size_code_i (size_code_i),
    .parity_i    (parity_i),
    .cfg_o       (cfg_live),
    .par_odd_o   (par_odd)
  );

  uftx_char_prep #(.DATA_W(DATA_W)) u_prep (
    .data_i      (data_i),
    .nbits_i     (cfg_live.nbits),
    .lsb_first_i (lsb_first_i),
    .ord_o       (ord),
    .xor_o       (pxor)
  );

  uftx_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .step_i    (step),
    .cfg_i     (cfg_live),
    .par_odd_i (par_odd),
    .char_i    (ord),
    .xor_i     (pxor),
    .ready_o   (ready_o),
    .busy_o    (busy_o),
    .tx_o      (tx_o),
    .sync_q_o  (sync_q),
    .inv_q_o   (inv_q)
  );

  // live settings while idle, frozen ones while a frame runs
  assign sync_act = busy_o ? sync_q : sync_mode_i;
  assign inv_act  = busy_o ? inv_q  : xck_inv_i;

  uftx_pacer u_pace (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (busy_o),
    .sync_i      (sync_act),
    .inv_i       (inv_act),
    .baud_tick_i (baud_tick_i),
    .step_o      (step),
    .xck_o       (xck_o)
  );

  a_r7_async_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !sync_q && !baud_tick_i) |=> $stable(tx_o));

  a_r8_stable_off_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && sync_q && (xck_o != inv_q)) |-> (tx_o == $past(tx_o)));

  a_r9_idle_rest_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (xck_o == xck_inv_i));

  a_r1_idle_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (tx_o && ready_o));
endmodule

// File: tb/usart_frame_tx_test.sv
`timescale 1ns/1ps
module usart_frame_tx_test;
  typedef struct packed {
    logic       sync;
    logic [2:0] code;
    logic [1:0] par;
    logic       two;
    logic       lsb;
    logic       inv;
    logic [8:0] data;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 2'b00, 1'b0, 1'b1, 1'b0, 9'h0A5},
    '{1'b0, 3'd5, 2'b10, 1'b0, 1'b0, 1'b0, 9'h013},
    '{1'b0, 3'd6, 2'b11, 1'b1, 1'b1, 1'b0, 9'h02D},
    '{1'b0, 3'd7, 2'b10, 1'b1, 1'b0, 1'b0, 9'h055},
    '{1'b0, 3'd1, 2'b11, 1'b0, 1'b1, 1'b0, 9'h1C3},
    '{1'b1, 3'd0, 2'b10, 1'b0, 1'b0, 1'b0, 9'h0F0},
    '{1'b1, 3'd1, 2'b00, 1'b1, 1'b0, 1'b1, 9'h155},
    '{1'b1, 3'd3, 2'b11, 1'b0, 1'b1, 1'b1, 9'h1FF},
    '{1'b0, 3'd6, 2'b01, 1'b0, 1'b0, 1'b0, 9'h13F}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sync_mode = 1'b0, tick = 1'b0, two_stop = 1'b0, lsb_first = 1'b0, xck_inv = 1'b0, valid = 1'b0;
  logic [2:0] size_code = 3'd0;
  logic [1:0] parity = 2'b00;
  logic [8:0] data = '0;
  logic ready, tx, xck, busy;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  usart_frame_tx uut (
    .clk_i(clk), .rst_ni(rst_ni), .sync_mode_i(sync_mode), .baud_tick_i(tick),
    .size_code_i(size_code), .parity_i(parity), .two_stop_i(two_stop),
    .lsb_first_i(lsb_first), .xck_inv_i(xck_inv), .data_i(data), .valid_i(valid),
    .ready_o(ready), .tx_o(tx), .xck_o(xck), .busy_o(busy)
  );

  initial begin : tick_gen
    int cnt = 0;
    forever begin
      @(posedge clk); #1;
      tick = (cnt == 2);
      cnt = (cnt + 1) % 3;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int build(input vec_t v, output logic [31:0] b);
    int nb, n, ones;
    nb = (v.code == 3'd5) ? 5 : (v.code == 3'd6) ? 6 : (v.code == 3'd7) ? 7 : (v.code == 3'd1) ? 9 : 8;
    b = '0; n = 1; ones = 0;
    for (int i = 0; i < nb; i++) begin
      automatic int k = v.lsb ? i : nb - 1 - i;
      b[n] = v.data[k];
      ones += int'(v.data[k]);
      n++;
    end
    if (v.par == 2'b10) begin b[n] = ones[0];  n++; end
    if (v.par == 2'b11) begin b[n] = ~ones[0]; n++; end
    b[n] = 1'b1; n++;
    if (v.two) begin b[n] = 1'b1; n++; end
    return n;
  endfunction

  task automatic apply(input vec_t v);
    sync_mode = v.sync; size_code = v.code; parity = v.par; two_stop = v.two;
    lsb_first = v.lsb; xck_inv = v.inv; data = v.data;
  endtask

  // send one character and rebuild the frame at the receiver's sampling point
  task automatic run_frame(input vec_t v, input bit disturb, output logic [31:0] got, output int n);
    int guard = 0;
    got = '0; n = 0;
    @(negedge clk);
    apply(v); valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    chk(busy && !tx && !ready, "R2 start bit after accept", {busy, tx, ready}, 3'b100);
    while (busy && guard < 4000) begin
      if (v.sync ? (xck != v.inv) : tick) begin
        got[n] = tx; n++;
      end
      if (disturb && n == 3) begin
        apply(~v); valid = 1'b1;
      end
      if (disturb && n == 6) valid = 1'b0;
      @(negedge clk);
      guard++;
    end
    valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] got, exp, e2;
    int n, en, en2;

    // R1 / R9: reset state, rest level follows polarity input
    xck_inv = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx && ready && !busy && xck, "R1 R9 in reset", {tx, ready, busy, xck}, 4'b1101);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(tx && ready && !busy && xck, "R1 after reset", {tx, ready, busy, xck}, 4'b1101);
    xck_inv = 1'b0;
    @(negedge clk);
    chk(!xck, "R9 idle rest follows input", xck, 0);

    // table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      run_frame(VECS[i], 1'b0, got, n);
      en = build(VECS[i], exp);
      chk(n == en && got == exp, $sformatf("R3 R4 R5 R6 R7 R8 frame vec %0d", i), got, exp);
      chk(tx && ready && !busy && xck == xck_inv, $sformatf("R1 R9 idle after vec %0d", i),
          {tx, ready, busy, xck}, {3'b110, xck_inv});
    end

    // R11 / R12: inputs disturbed and valid raised mid-frame
    for (int j = 0; j < 2; j++) begin
      automatic vec_t v = (j == 0) ? VECS[5] : VECS[2];
      run_frame(v, 1'b1, got, n);
      en = build(v, exp);
      chk(n == en && got == exp, $sformatf("R11 frame unaffected by input change %0d", j), got, exp);
      repeat (12) @(negedge clk);
      chk(!busy && tx, $sformatf("R12 no extra frame %0d", j), {busy, tx}, 2'b01);
    end

    // R10: back-to-back frames in synchronous mode, no idle gap
    begin
      vec_t va, vb;
      int busy_cnt = 0;
      bit dropped = 1'b0;
      va = '{1'b1, 3'd0, 2'b00, 1'b0, 1'b0, 1'b0, 9'h03C};
      vb = '{1'b1, 3'd0, 2'b00, 1'b0, 1'b0, 1'b0, 9'h0C5};
      got = '0; n = 0;
      @(negedge clk);
      apply(va); valid = 1'b1;
      @(negedge clk);
      data = vb.data;
      for (int c = 0; c < 40; c++) begin
        if (busy) busy_cnt++;
        if (xck != 1'b0) begin got[n] = tx; n++; end
        if (ready && !dropped) dropped = 1'b1;
        else if (dropped) valid = 1'b0;
        @(negedge clk);
      end
      valid = 1'b0;
      en = build(va, exp);
      en2 = build(vb, e2);
      exp = exp | (e2 << en);
      chk(busy_cnt == 40 && !busy, "R10 continuous busy, no gap", busy_cnt, 40);
      chk(n == en + en2 && got == exp, "R10 back-to-back frame contents", got, exp);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule